// File: doc/BRIEF.md
# Synchronous Clock Power-Down Gate

This block sits at the output of a clock generator and decides, per output, whether a source clock is passed through or held low. A single active-low power-down request is synchronised into a reference CPU clock domain. It is accepted only after it has been seen at the same level on a set number of consecutive reference rising edges. The qualified request is then carried into every output clock domain. There it controls a gate element that changes state only while that output's clock is low. As a result, no output ever produces a shortened high pulse, whether it is stopping or restarting.

Each output also has its own enable bit from the configuration registers. A disabled output is held low, and it stops and restarts on its own falling edge in the same glitch-free way as for power-down. A status flag in the reference domain goes high once power-down has been qualified and every output has reached the stopped state.

The gate element can be a negative-edge flop or a low-transparent latch, chosen by a parameter. The synchroniser depth and the qualification count are also parameters.

Top module: `clk_pwrdn_gate`

## Requirements
- R1: While `rst_n` is low, every bit of `gclk_out` and `all_stopped` is 0.
- R2: A low level on `pd_n` that lasts fewer than `QUAL_CNT` (default 2) consecutive `ref_clk` rising edges does not start power-down: enabled outputs keep toggling with no missed pulse, and `all_stopped` stays 0.
- R3: A low level on `pd_n` held for `QUAL_CNT` consecutive `ref_clk` rising edges starts power-down: enabled outputs drop at least one pulse.
- R4: While power-down is in effect, every bit of `gclk_out` is held at 0 with no edges.
- R5: Every high phase on a `gclk_out` bit lasts exactly one full high phase of its source clock. This holds across power-down entry and exit and across enable changes, so truncated pulses never occur.
- R6: Outside power-down, output i toggles when `out_en[i]` is 1 and is held at 0 when `out_en[i]` is 0. Each bit acts independently of the others.
- R7: After `pd_n` returns high for `QUAL_CNT` consecutive `ref_clk` rising edges, the enabled outputs resume toggling and `all_stopped` returns to 0.
- R8: `all_stopped` is 1 only while power-down is qualified and every output has stopped. It rises within 30 `ref_clk` cycles of a sustained low on `pd_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference CPU clock; `pd_n` is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| pd_n | input | 1 | Active-low power-down request, asynchronous to all clocks |
| src_clk | input | N_OUT | Free-running source clocks, one per output |
| out_en | input | N_OUT | Per-output enable, 1 = pass clock, 0 = hold low |
| gclk_out | output | N_OUT | Gated clocks |
| all_stopped | output | 1 | High when power-down is qualified and all outputs are stopped |

## Verification
A change on `pd_n` becomes the qualified request at the fourth `ref_clk` rising edge: two synchroniser edges plus `QUAL_CNT` qualification edges. Each output then follows after two rising edges of its own clock and the falling edge after them. The status flag adds two more reference edges and one register. The bench therefore lets 30 reference cycles pass after every stimulus, which is longer than the worst case of this chain for the slowest test clock. It then counts output edges over a further 40-cycle window and compares the count with the value predicted by its own model. The qualification boundary, where one low sample is ignored and two are accepted, is checked by timing the gaps between rising edges of the fastest output. Pulse widths are measured continuously against each source half period.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;
   // gate element variants
   localparam int GATE_FLOP  = 0;
   localparam int GATE_LATCH = 1;

   // width needed to hold values 0..n
   function automatic int cnt_width(input int n);
      int w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction
endpackage

// File: rtl/clkpd_sync.sv
module clkpd_sync #(
   parameter int WIDTH     = 1,
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("clkpd_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= {WIDTH{RESET_VAL}};
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkpd_qualify.sv
module clkpd_qualify
   import clkpd_pkg::*;
#(
   parameter int QUAL_CNT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic low_s,    // synchronised "pd requested" level
   output logic pd_req
);
   localparam int CW = cnt_width(QUAL_CNT);
   localparam logic [CW-1:0] LAST = CW'(QUAL_CNT - 1);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         pd_req  <= 1'b0;
      end else if (low_s != pd_req) begin
         if (run_cnt == LAST) begin
            pd_req  <= low_s;
            run_cnt <= '0;
         end else begin
            run_cnt <= run_cnt + 1'b1;
         end
      end else begin
         run_cnt <= '0;
      end
   end

   // entry only after a low sample was seen
   assert_enter_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_req) |-> $past(low_s));
   // exit only after a high sample was seen
   assert_exit_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_req) |-> !$past(low_s));
   // run counter stays below the qualification length
   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= LAST);
endmodule

// File: rtl/clkpd_gate.sv
module clkpd_gate
   import clkpd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int GATE_KIND   = GATE_FLOP
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic en,
   input  logic pd_req,
   output logic gclk,
   output logic stopped
);
   logic [1:0] ctl_s;
   logic       en_s, pd_s, gate_d, gate_q;

   clkpd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_ctl_sync (
      .clk   (src_clk),
      .rst_n (rst_n),
      .d     ({en, pd_req}),
      .q     (ctl_s)
   );

   assign en_s   = ctl_s[1];
   assign pd_s   = ctl_s[0];
   assign gate_d = en_s & ~pd_s;

   generate
      if (GATE_KIND == GATE_LATCH) begin : g_latch
         always_latch begin
            if (!rst_n)        gate_q = 1'b0;
            else if (!src_clk) gate_q = gate_d;
         end
      end else begin : g_flop
         always_ff @(negedge src_clk or negedge rst_n) begin
            if (!rst_n) gate_q <= 1'b0;
            else        gate_q <= gate_d;
         end
      end
   endgenerate

   assign gclk    = src_clk & gate_q;
   assign stopped = ~gate_q;

   // checker support: gate value captured at each rising edge
   logic gate_at_rise;
   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) gate_at_rise <= 1'b0;
      else        gate_at_rise <= gate_q;
   end

   // gate never moves during the high phase
   assert_gate_stable_high_R5: assert property (@(negedge src_clk) disable iff (!rst_n)
      gate_q == gate_at_rise);
   // a disabled output stays gated off
   assert_disabled_low_R6: assert property (@(negedge src_clk) disable iff (!rst_n)
      $past(!en_s) |-> !gate_q);
endmodule

// File: rtl/clkpd_status.sv
module clkpd_status #(
   parameter int N_OUT       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_req,
   input  logic [N_OUT-1:0] stopped,
   output logic             all_stopped
);
   logic [N_OUT-1:0] stop_s;

   clkpd_sync #(.WIDTH(N_OUT), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_stop_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (stopped),
      .q     (stop_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) all_stopped <= 1'b0;
      else        all_stopped <= pd_req & (&stop_s);
   end
endmodule

// File: rtl/clk_pwrdn_gate.sv
module clk_pwrdn_gate
   import clkpd_pkg::*;
#(
   parameter int N_OUT       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_CNT    = 2,
   parameter int GATE_KIND   = GATE_FLOP
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             pd_n,
   input  logic [N_OUT-1:0] src_clk,
   input  logic [N_OUT-1:0] out_en,
   output logic [N_OUT-1:0] gclk_out,
   output logic             all_stopped
);
   generate
      if (N_OUT < 1)       begin : g_chk_n   $error("N_OUT must be positive"); end
      if (QUAL_CNT < 1)    begin : g_chk_q   $error("QUAL_CNT must be positive"); end
      if (SYNC_STAGES < 2) begin : g_chk_s   $error("SYNC_STAGES must be at least 2"); end
      if (GATE_KIND != GATE_FLOP && GATE_KIND != GATE_LATCH) begin : g_chk_k
         $error("GATE_KIND selects an unknown gate element");
      end
   endgenerate

   logic             low_s;
   logic             pd_req;
   logic [N_OUT-1:0] stopped;

   clkpd_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_pd_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (~pd_n),
      .q     (low_s)
   );

   clkpd_qualify #(.QUAL_CNT(QUAL_CNT)) u_qual (
      .clk    (ref_clk),
      .rst_n  (rst_n),
      .low_s  (low_s),
      .pd_req (pd_req)
   );

   generate
      for (genvar i = 0; i < N_OUT; i++) begin : g_out
         clkpd_gate #(.SYNC_STAGES(SYNC_STAGES), .GATE_KIND(GATE_KIND)) u_gate (
            .src_clk (src_clk[i]),
            .rst_n   (rst_n),
            .en      (out_en[i]),
            .pd_req  (pd_req),
            .gclk    (gclk_out[i]),
            .stopped (stopped[i])
         );
      end
   endgenerate

   clkpd_status #(.N_OUT(N_OUT), .SYNC_STAGES(SYNC_STAGES)) u_status (
      .clk         (ref_clk),
      .rst_n       (rst_n),
      .pd_req      (pd_req),
      .stopped     (stopped),
      .all_stopped (all_stopped)
   );

   // status implies a qualified request
   assert_status_in_pd_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
      all_stopped |-> $past(pd_req));
endmodule

// File: tb/clk_pwrdn_gate_test.sv
`timescale 1ns/1ps
module clk_pwrdn_gate_test;
   localparam int N = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pd_n = 1'b1;
   logic [N-1:0] en = '1;
   logic       c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0;
   logic [N-1:0] src;
   logic [N-1:0] gclk;
   logic       all_stopped;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   assign src = {c3, c2, c1, c0};

   clk_pwrdn_gate #(.N_OUT(N)) uut (
      .ref_clk(clk), .rst_n(rst_n), .pd_n(pd_n), .src_clk(src),
      .out_en(en), .gclk_out(gclk), .all_stopped(all_stopped)
   );

   always #4 clk = ~clk;   // 125 MHz
   initial begin #1.0; forever #4.0 c0 = ~c0; end
   initial begin #0.5; forever #3.0 c1 = ~c1; end
   initial begin #2.0; forever #8.0 c2 = ~c2; end
   initial begin #3.0; forever #7.0 c3 = ~c3; end

   function automatic real half_of(input int i);
      case (i)
         0: return 4.0;
         1: return 3.0;
         2: return 8.0;
         default: return 7.0;
      endcase
   endfunction

   // expected toggling per output from the requirements
   function automatic bit exp_toggle(input logic [N-1:0] e, input int i, input bit in_pd);
      return !in_pd && e[i];
   endfunction

   // monitors: counters are only ever incremented here
   int edge_cnt [N];
   int width_err = 0;
   int gap_cnt = 0;
   int stop_rise = 0;
   real last_rise1 = -1.0;

   for (genvar gi = 0; gi < N; gi++) begin : g_mon
      real rise_t = -1.0;
      initial edge_cnt[gi] = 0;
      always @(posedge gclk[gi]) begin
         edge_cnt[gi]++;
         rise_t = $realtime;
      end
      always @(negedge gclk[gi]) begin
         if (rise_t >= 0.0) begin
            real w;
            w = $realtime - rise_t;
            if (w < half_of(gi) - 0.01 || w > half_of(gi) + 0.01) begin
               width_err++;
               $display("FAIL R5 out%0d high width actual=%0.2f expected=%0.2f", gi, w, half_of(gi));
            end
         end
      end
   end

   always @(posedge gclk[1]) begin
      if (last_rise1 >= 0.0 && ($realtime - last_rise1) > 9.0) gap_cnt++;
      last_rise1 = $realtime;
   end
   always @(posedge all_stopped) stop_rise++;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_ref(input int n);
      repeat (n) @(negedge clk);
   endtask

   // count edges per output across a 40-cycle window, compare with model
   task automatic window_check(input string req, input bit in_pd);
      int base [N];
      for (int i = 0; i < N; i++) base[i] = edge_cnt[i];
      wait_ref(40);
      for (int i = 0; i < N; i++) begin
         int d;
         d = edge_cnt[i] - base[i];
         check((d > 0) == exp_toggle(en, i, in_pd), req, $sformatf("out%0d toggling", i),
               (d > 0) ? 1 : 0, exp_toggle(en, i, in_pd) ? 1 : 0);
         if (!exp_toggle(en, i, in_pd))
            check(gclk[i] == 1'b0, req, $sformatf("out%0d level", i), gclk[i], 0);
      end
   endtask

   task automatic pd_pulse(input int n);
      pd_n = 1'b0;
      wait_ref(n);
      pd_n = 1'b1;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state
      wait_ref(3);
      check(gclk == '0, "R1", "outputs in reset", gclk, 0);
      check(all_stopped == 1'b0, "R1", "status in reset", all_stopped, 0);
      #5.3;
      check(gclk == '0, "R1", "outputs in reset later", gclk, 0);
      wait_ref(1);
      rst_n = 1'b1;
      wait_ref(30);
      window_check("R6", 1'b0);
      check(all_stopped == 1'b0, "R8", "status while running", all_stopped, 0);

      // R2: one low sample is ignored
      begin
         int g0, s0;
         g0 = gap_cnt; s0 = stop_rise;
         pd_pulse(1);
         wait_ref(40);
         check(gap_cnt == g0, "R2", "missed pulses after short low", gap_cnt - g0, 0);
         check(stop_rise == s0, "R2", "status rises after short low", stop_rise - s0, 0);
      end

      // R3: QUAL_CNT low samples start power-down
      begin
         int g0;
         g0 = gap_cnt;
         pd_pulse(2);
         wait_ref(40);
         check(gap_cnt > g0, "R3", "missed pulse after qualified low", gap_cnt - g0, 1);
      end

      // R4 / R8: sustained power-down
      pd_n = 1'b0;
      wait_ref(30);
      check(all_stopped == 1'b1, "R8", "status in power-down", all_stopped, 1);
      window_check("R4", 1'b1);
      // R7: exit
      pd_n = 1'b1;
      wait_ref(30);
      check(all_stopped == 1'b0, "R7", "status after exit", all_stopped, 0);
      window_check("R7", 1'b0);

      // R6: mixed enables
      en = 4'b1010;
      wait_ref(30);
      window_check("R6", 1'b0);
      en = 4'b0101;
      wait_ref(30);
      window_check("R6", 1'b0);

      // random mix of enables and short / long requests
      for (int it = 0; it < 10; it++) begin
         en = N'($urandom);
         wait_ref(30);
         if ($urandom % 2 == 0) begin
            int s0;
            s0 = stop_rise;
            pd_pulse(1);
            wait_ref(30);
            check(stop_rise == s0, "R2", "status after random short low", stop_rise - s0, 0);
            window_check("R6", 1'b0);
         end else begin
            pd_n = 1'b0;
            wait_ref(30 + int'($urandom % 10));
            check(all_stopped == 1'b1, "R8", "status random power-down", all_stopped, 1);
            window_check("R4", 1'b1);
            pd_n = 1'b1;
            wait_ref(30);
            check(all_stopped == 1'b0, "R7", "status random exit", all_stopped, 0);
            window_check("R7", 1'b0);
         end
      end

      check(width_err == 0, "R5", "truncated high phases", width_err, 0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule